// File: doc/BRIEF.md
# Data Output Edge Conditioner

This block turns the raw output of a receiver demodulator into a clean data line for a host microcontroller. The demodulator level is looked at only on ticks of a slower extended clock, so every output edge lands on a tick boundary. After each output edge the line is held for at least a programmable number of ticks, which swallows spikes and caps the rate of edges the host has to service as interrupts.

A second timer limits how long the line may stay low. When the limit runs out the line is driven high and stays high until the demodulator has been seen high again, so the host always gets the line back within a bounded time even if the demodulator sits low. Outside receiving mode the line idles high and both timers are cleared.

Top module: `data_edge_cond`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `data_out` is 1.
- R2: When `rx_mode` is 0, `data_out` is 1 from the next clock on, whatever `demod_in` and `xclk_tick` do.
- R3: In receiving mode `data_out` changes only at a clock edge where `xclk_tick` is 1; changes of `demod_in` between ticks have no effect.
- R4: At a tick where `demod_in` differs from `data_out` and at least `min_gap` ticks have elapsed since the last output edge (the current tick counted), `data_out` takes the value of `demod_in` at that clock edge.
- R5: A change of `demod_in` that arrives before `min_gap` ticks have elapsed is held back and appears at the first tick at which the spacing is met, provided `demod_in` still differs then.
- R6: A level change of `demod_in` that returns to the output level before the spacing since the last output edge has elapsed produces no output edge.
- R7: After a falling edge of `data_out`, at the tick that completes `max_low` ticks of low time, `data_out` is forced to 1 even if `demod_in` is still 0.
- R8: After such a forced rise, `data_out` stays 1 until `demod_in` has been 1 at a tick; only a later 0 on `demod_in` can bring it low again.
- R9: A forced rise restarts the spacing: the next falling edge needs `min_gap` ticks after it.
- R10: On entry to receiving mode the spacing count starts at zero, so the first falling edge needs `min_gap` ticks in receiving mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xclk_tick | input | 1 | One-cycle enable at the extended clock rate |
| demod_in | input | 1 | Raw demodulator level, synchronous to `clk` |
| rx_mode | input | 1 | 1 while the receiver is in receiving mode |
| min_gap | input | GAP_W | Minimum spacing between output edges, in ticks |
| max_low | input | LOW_W | Longest low time of the output, in ticks |
| data_out | output | 1 | Conditioned data line |

## Verification
The main path is driven with a tick-by-tick table whose demodulator patterns separate the cases: a level change after the spacing has run out (passes at once), a change inside the spacing that persists (delayed to the first legal tick), a short spike inside the spacing (vanishes), and a long low stretch (cut off by the low-time limit and then locked high). Between ticks the demodulator is flipped to show that only tick cycles matter. A second pass with a spacing of one tick shows the line tracking every tick, and dropping receiving mode while the line is low shows the idle-high behaviour.

// File: rtl/dec_pkg.sv
package dec_pkg;

    // Lock raised by the low-time limit, released once the input is seen high.
    typedef enum logic {
        LOCK_OFF = 1'b0,
        LOCK_ON  = 1'b1
    } lock_e;

    typedef struct packed {
        logic  line;
        lock_e lock;
    } line_state_t;

    localparam line_state_t LINE_IDLE = '{line: 1'b1, lock: LOCK_OFF};

endpackage

// File: rtl/dec_tick_counter.sv
module dec_tick_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    output logic [W-1:0] count_q
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] count_d;

    always_comb begin
        count_d = count_q;
        if (clear) begin
            count_d = '0;
        end else if (tick && (count_q != CNT_MAX)) begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end
endmodule

// File: rtl/dec_edge_ctrl.sv
module dec_edge_ctrl
    import dec_pkg::*;
#(
    parameter int GAP_W = 8,
    parameter int LOW_W = 16
) (
    input  logic             rx_mode,
    input  logic             tick,
    input  logic             demod,
    input  line_state_t      st_q,
    input  logic [GAP_W-1:0] gap_q,
    input  logic [LOW_W-1:0] low_q,
    input  logic [GAP_W-1:0] min_gap,
    input  logic [LOW_W-1:0] max_low,
    output line_state_t      st_d,
    output logic             edge_now
);
    // One extra bit so the elapsed count never wraps.
    localparam int GE_W = GAP_W + 1;
    localparam int LE_W = LOW_W + 1;

    logic [GE_W-1:0] gap_elapsed;
    logic [LE_W-1:0] low_elapsed;
    logic            gap_met;
    logic            low_expired;
    logic            want;

    always_comb begin
        gap_elapsed = {1'b0, gap_q} + GE_W'(1);
        low_elapsed = {1'b0, low_q} + LE_W'(1);
        gap_met     = gap_elapsed >= {1'b0, min_gap};
        low_expired = !st_q.line && (low_elapsed >= {1'b0, max_low});

        st_d     = st_q;
        edge_now = 1'b0;
        want     = demod;

        if (!rx_mode) begin
            st_d     = LINE_IDLE;
            edge_now = !st_q.line;
        end else if (tick) begin
            if (st_q.lock == LOCK_ON) begin
                want = 1'b1;
                if (demod) begin
                    st_d.lock = LOCK_OFF;
                end
            end
            if (low_expired) begin
                st_d.line = 1'b1;
                st_d.lock = demod ? LOCK_OFF : LOCK_ON;
                edge_now  = 1'b1;
            end else if ((want != st_q.line) && gap_met) begin
                st_d.line = want;
                edge_now  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/data_edge_cond.sv
module data_edge_cond
    import dec_pkg::*;
#(
    parameter int GAP_W = 8,
    parameter int LOW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xclk_tick,
    input  logic             demod_in,
    input  logic             rx_mode,
    input  logic [GAP_W-1:0] min_gap,
    input  logic [LOW_W-1:0] max_low,
    output logic             data_out
);
    line_state_t      st_d, st_q;
    logic             edge_now;
    logic [GAP_W-1:0] gap_q;
    logic [LOW_W-1:0] low_q;
    logic             gap_clear;
    logic             low_clear;

    dec_edge_ctrl #(.GAP_W(GAP_W), .LOW_W(LOW_W)) u_ctrl (
        .rx_mode (rx_mode),
        .tick    (xclk_tick),
        .demod   (demod_in),
        .st_q    (st_q),
        .gap_q   (gap_q),
        .low_q   (low_q),
        .min_gap (min_gap),
        .max_low (max_low),
        .st_d    (st_d),
        .edge_now(edge_now)
    );

    always_comb begin
        gap_clear = !rx_mode || edge_now;
        low_clear = !rx_mode || edge_now || st_q.line;
    end

    dec_tick_counter #(.W(GAP_W)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (gap_clear),
        .tick   (xclk_tick),
        .count_q(gap_q)
    );

    dec_tick_counter #(.W(LOW_W)) u_low (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (low_clear),
        .tick   (xclk_tick),
        .count_q(low_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= LINE_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_out = st_q.line;
endmodule

// File: rtl/dec_checker.sv
module dec_checker #(
    parameter int GAP_W = 8,
    parameter int LOW_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xclk_tick,
    input logic             rx_mode,
    input logic [GAP_W-1:0] min_gap,
    input logic [LOW_W-1:0] max_low,
    input logic             data_out
);
    localparam logic [GAP_W-1:0] G_MAX = '1;
    localparam logic [LOW_W-1:0] L_MAX = '1;

    logic             last_q;
    logic [GAP_W-1:0] gcnt_q;
    logic [LOW_W-1:0] lcnt_q;

    // Ticks seen since the last observed output change.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= 1'b1;
            gcnt_q <= '0;
            lcnt_q <= '0;
        end else begin
            last_q <= data_out;
            if (!rx_mode) begin
                gcnt_q <= '0;
            end else if (data_out != last_q) begin
                gcnt_q <= xclk_tick ? GAP_W'(1) : '0;
            end else if (xclk_tick && gcnt_q != G_MAX) begin
                gcnt_q <= gcnt_q + 1'b1;
            end
            if (!rx_mode || data_out) begin
                lcnt_q <= '0;
            end else if (data_out != last_q) begin
                lcnt_q <= xclk_tick ? LOW_W'(1) : '0;
            end else if (xclk_tick && lcnt_q != L_MAX) begin
                lcnt_q <= lcnt_q + 1'b1;
            end
        end
    end

    // R2
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_mode |=> data_out);

    // R3
    tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_mode) && (data_out != $past(data_out))) |-> $past(xclk_tick));

    // R5
    min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_out) |->
            (({1'b0, $past(gcnt_q)} + (GAP_W + 1)'(1)) >= {1'b0, $past(min_gap)}));

    // R7
    low_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_mode && !data_out && max_low != '0) |-> (lcnt_q < max_low));
endmodule

bind data_edge_cond dec_checker #(.GAP_W(GAP_W), .LOW_W(LOW_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .xclk_tick(xclk_tick),
    .rx_mode  (rx_mode),
    .min_gap  (min_gap),
    .max_low  (max_low),
    .data_out (data_out)
);

// File: tb/tb_data_edge_cond.sv
module tb_data_edge_cond;
    localparam int GAP_W = 8;
    localparam int LOW_W = 16;
    localparam int NV    = 34;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             xclk_tick = 1'b0;
    logic             demod_in = 1'b1;
    logic             rx_mode = 1'b1;
    logic [GAP_W-1:0] min_gap = GAP_W'(3);
    logic [LOW_W-1:0] max_low = LOW_W'(5);
    logic             data_out;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    data_edge_cond #(.GAP_W(GAP_W), .LOW_W(LOW_W)) dut (
        .clk(clk), .rst_n(rst_n), .xclk_tick(xclk_tick), .demod_in(demod_in),
        .rx_mode(rx_mode), .min_gap(min_gap), .max_low(max_low), .data_out(data_out)
    );

    // Per tick: {demod level, expected data_out}; spacing 3, low limit 5.
    localparam logic [1:0] VEC [NV] = '{
        2'b01, 2'b01, 2'b00,                          // R10 first fall at tick 3
        2'b10, 2'b00, 2'b00,                          // R6 spike inside spacing
        2'b11,                                        // R4 rise once spacing met
        2'b01, 2'b01, 2'b00,                          // R5 fall delayed to tick 3
        2'b00, 2'b00, 2'b00, 2'b00, 2'b01,            // R7 forced high after 5
        2'b01, 2'b01, 2'b01, 2'b11, 2'b00,            // R8 locked until input high
        2'b10, 2'b10, 2'b11,                          // R5 rise delayed
        2'b01, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b01, // R7 again
        2'b11, 2'b01, 2'b00                           // R9 spacing restarts
    };
    localparam int TAG [NV] = '{
        10, 10, 10, 6, 6, 6, 4, 5, 5, 5,
        7, 7, 7, 7, 7, 8, 8, 8, 8, 8,
        5, 5, 5, 7, 7, 7, 7, 7, 7, 7, 7,
        9, 9, 9
    };

    task automatic check(input int req, input logic exp, input string what);
        n_run++;
        if (data_out !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: data_out=%b expected %b", req, what, data_out, exp);
        end
    endtask

    // One tick cycle, then a non-tick cycle with the input flipped (R3).
    task automatic do_tick(input logic d, input logic exp, input int req);
        @(negedge clk);
        demod_in  = d;
        xclk_tick = 1'b1;
        @(negedge clk);
        xclk_tick = 1'b0;
        check(req, exp, "after tick");
        demod_in = ~d;
        @(negedge clk);
        check(3, exp, "R3 no change between ticks");
        demod_in = d;
    endtask

    initial begin
        #(8 * 20000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state, even with receiving mode and a low input
        demod_in = 1'b0;
        repeat (3) @(negedge clk);
        check(1, 1'b1, "R1 during reset");
        rst_n   = 1'b1;
        rx_mode = 1'b0;
        @(negedge clk);
        check(1, 1'b1, "R1 after reset");

        rx_mode = 1'b1;
        for (int i = 0; i < NV; i++) begin
            do_tick(VEC[i][1], VEC[i][0], TAG[i]);
        end

        // R2: leaving receiving mode while low
        check(2, 1'b0, "R2 precondition low");
        @(negedge clk);
        rx_mode = 1'b0;
        @(negedge clk);
        check(2, 1'b1, "R2 idle high next clock");
        do_tick(1'b0, 1'b1, 2);
        do_tick(1'b0, 1'b1, 2);

        // R4: spacing of one tick follows every tick
        min_gap = GAP_W'(1);
        rx_mode = 1'b1;
        do_tick(1'b0, 1'b0, 4);
        do_tick(1'b1, 1'b1, 4);
        do_tick(1'b0, 1'b0, 4);
        do_tick(1'b1, 1'b1, 4);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule